// File: doc/BRIEF.md
# Pseudo-static RAM configuration register write sequencer

This block sits on the controller side of an asynchronous parallel pseudo-static RAM bus. It programs one of the memory's two configuration registers on request. After the write, it issues a plain array read so that the bus is known to be back in normal array mode. The register value does not travel on the data lines. It is driven on the 21-bit address bus while a sideband config-enable pin is high. One address bit chooses between the bus configuration register and the refresh configuration register.

The host supplies a register select, a 21-bit value, an array address for the follow-up read and five phase lengths counted in clock cycles. The sequencer walks through a fixed strobe order: setup, address-valid pulse, write pulse, hold and read access. It reports completion with a one-cycle done pulse, together with the 16-bit word it read. A request to read a configuration register is refused with an error pulse, because the config-enable path supports writes only.

Top module: `psram_cfg_seq`

## Requirements
- R1: After reset and whenever idle: CE#, ADV#, WE#, OE#, LB# and UB# are high, CRE is low, and busy_o, done_o and err_o are low.
- R2: A write request (req_i high, rd_req_i low) is accepted only when idle. busy_o then stays high until the cycle in which done_o rises. Requests seen while busy are ignored, so exactly one register write happens per accepted request.
- R3: During the register write, the address bus carries cfg_val_i with bit 19 replaced by reg_sel_i (1 = bus configuration register, 0 = refresh configuration register). The address holds steady for as long as CRE is high.
- R4: The write order is fixed. First comes a setup phase of t_setup cycles with CRE high, CE# low and ADV#/WE# high. Next, ADV# goes low alone for t_adv cycles. Then WE# goes low, with ADV# still low, for t_we cycles. Finally ADV#, WE# and CE# all rise on the same edge.
- R5: After the strobes rise, CRE and the address stay unchanged for t_hold cycles while all strobes are high.
- R6: OE# stays high, and LB#/UB# stay high, whenever CRE is high.
- R7: A phase length of 0 is treated as 1 cycle. Phase lengths are captured when the request is accepted.
- R8: The follow-up read drives CRE low, drives CE#, ADV#, OE#, LB# and UB# low, and places arr_addr_i on the address bus, for t_acc cycles.
- R9: At the edge that ends the read, rd_data_o takes the value on mem_dq_i and done_o is high for exactly one cycle.
- R10: rd_req_i while idle causes a one-cycle err_o pulse in the next cycle. It causes no bus activity and no done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Register write request |
| rd_req_i | input | 1 | Register read request (always refused) |
| reg_sel_i | input | 1 | 1 = bus configuration register, 0 = refresh configuration register |
| cfg_val_i | input | 21 | Register value |
| arr_addr_i | input | 21 | Array address for the follow-up read |
| t_setup_i | input | 8 | Setup phase length in cycles |
| t_adv_i | input | 8 | ADV#-only pulse length in cycles |
| t_we_i | input | 8 | WE# pulse length in cycles |
| t_hold_i | input | 8 | Hold phase length in cycles |
| t_acc_i | input | 8 | Read access length in cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse for a read request |
| rd_data_o | output | 16 | Word from the follow-up read |
| mem_addr_o | output | 21 | Memory address bus |
| mem_cre_o | output | 1 | Config-enable pin, active high |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_lb_n_o | output | 1 | Lower byte enable, active low |
| mem_ub_n_o | output | 1 | Upper byte enable, active low |
| mem_dq_i | input | 16 | Memory data bus, read side |

## Verification
The main write sequence is exercised with values whose bit 19 disagrees with the select, in both directions. This shows that the select really overrides the value rather than passing the value through. The phase lengths are varied across runs: all ones, all zeros, and mixes of long and short phases. Measuring every phase width at the pins therefore separates a swapped or miscounted phase from a correct one, and the zero case separates the clamp-to-one rule from a zero-length or wrapped phase. A request pulsed mid-sequence and a read request at idle show whether stray inputs are ignored or refused without touching the bus.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    localparam int ADDR_W  = 21;
    localparam int DATA_W  = 16;
    localparam int CNT_W   = 8;
    localparam int SEL_BIT = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADV,
        ST_WE,
        ST_HOLD,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] adv;
        logic [CNT_W-1:0] we;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] acc;
    } phase_len_t;

    typedef struct packed {
        logic              cre;
        logic              ce_n;
        logic              adv_n;
        logic              we_n;
        logic              oe_n;
        logic              lb_n;
        logic              ub_n;
        logic [ADDR_W-1:0] addr;
    } bus_pins_t;

    // Zero-length phases are stretched to one cycle.
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

    // Register value with the select bit forced into its address position.
    function automatic logic [ADDR_W-1:0] cfg_word(input logic sel,
                                                  input logic [ADDR_W-1:0] val);
        logic [ADDR_W-1:0] w;
        w          = val;
        w[SEL_BIT] = sel;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] len_for(input seq_state_e st,
                                                 input phase_len_t pl);
        case (st)
            ST_SETUP: return eff_len(pl.setup);
            ST_ADV:   return eff_len(pl.adv);
            ST_WE:    return eff_len(pl.we);
            ST_HOLD:  return eff_len(pl.hold);
            ST_READ:  return eff_len(pl.acc);
            default:  return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/psram_cfg_timer.sv
module psram_cfg_timer #(
    parameter int CW = psram_cfg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/psram_cfg_busdrv.sv
module psram_cfg_busdrv
    import psram_cfg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  seq_state_e  state,
    input  logic [AW-1:0] wr_word,
    input  logic [AW-1:0] rd_addr,
    output bus_pins_t   pins
);
    always_comb begin
        pins       = '{cre: 1'b0, ce_n: 1'b1, adv_n: 1'b1, we_n: 1'b1,
                       oe_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, addr: '0};
        unique case (state)
            ST_SETUP: begin
                pins.cre  = 1'b1;
                pins.ce_n = 1'b0;
                pins.addr = wr_word;
            end
            ST_ADV: begin
                pins.cre   = 1'b1;
                pins.ce_n  = 1'b0;
                pins.adv_n = 1'b0;
                pins.addr  = wr_word;
            end
            ST_WE: begin
                pins.cre   = 1'b1;
                pins.ce_n  = 1'b0;
                pins.adv_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.addr  = wr_word;
            end
            ST_HOLD: begin
                pins.cre  = 1'b1;
                pins.addr = wr_word;
            end
            ST_READ: begin
                pins.ce_n  = 1'b0;
                pins.adv_n = 1'b0;
                pins.oe_n  = 1'b0;
                pins.lb_n  = 1'b0;
                pins.ub_n  = 1'b0;
                pins.addr  = rd_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
    import psram_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          rd_req_i,
    input  logic          reg_sel_i,
    input  logic [AW-1:0] cfg_val_i,
    input  logic [AW-1:0] arr_addr_i,
    input  logic [CW-1:0] t_setup_i,
    input  logic [CW-1:0] t_adv_i,
    input  logic [CW-1:0] t_we_i,
    input  logic [CW-1:0] t_hold_i,
    input  logic [CW-1:0] t_acc_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rd_data_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_cre_o,
    output logic          mem_ce_n_o,
    output logic          mem_adv_n_o,
    output logic          mem_we_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_lb_n_o,
    output logic          mem_ub_n_o,
    input  logic [DW-1:0] mem_dq_i
);
    seq_state_e    state_q, state_d;
    phase_len_t    len_q, len_in, len_sel;
    logic [AW-1:0] word_q, rd_addr_q;
    logic [DW-1:0] data_q;
    logic          done_q, err_q;
    logic          accept, phase_end, t_load;
    logic [CW-1:0] t_len;
    bus_pins_t     pins;

    assign len_in = '{setup: t_setup_i, adv: t_adv_i, we: t_we_i,
                      hold: t_hold_i, acc: t_acc_i};
    assign accept = (state_q == ST_IDLE) && req_i && !rd_req_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_SETUP;
            ST_SETUP: if (phase_end) state_d = ST_ADV;
            ST_ADV:   if (phase_end) state_d = ST_WE;
            ST_WE:    if (phase_end) state_d = ST_HOLD;
            ST_HOLD:  if (phase_end) state_d = ST_READ;
            ST_READ:  if (phase_end) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Lengths come straight from the inputs on the accepting edge.
    assign len_sel = (state_q == ST_IDLE) ? len_in : len_q;
    assign t_load  = (state_d != state_q);
    assign t_len   = len_for(state_d, len_sel);

    psram_cfg_timer #(.CW(CW)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .last (phase_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            len_q     <= '0;
            word_q    <= '0;
            rd_addr_q <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_READ) && phase_end;
            err_q   <= (state_q == ST_IDLE) && rd_req_i;
            if (accept) begin
                len_q     <= len_in;
                word_q    <= cfg_word(reg_sel_i, cfg_val_i);
                rd_addr_q <= arr_addr_i;
            end
            if ((state_q == ST_READ) && phase_end) begin
                data_q <= mem_dq_i;
            end
        end
    end

    psram_cfg_busdrv #(.AW(AW)) busdrv_i (
        .state   (state_q),
        .wr_word (word_q),
        .rd_addr (rd_addr_q),
        .pins    (pins)
    );

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign rd_data_o   = data_q;
    assign mem_addr_o  = pins.addr;
    assign mem_cre_o   = pins.cre;
    assign mem_ce_n_o  = pins.ce_n;
    assign mem_adv_n_o = pins.adv_n;
    assign mem_we_n_o  = pins.we_n;
    assign mem_oe_n_o  = pins.oe_n;
    assign mem_lb_n_o  = pins.lb_n;
    assign mem_ub_n_o  = pins.ub_n;

    // R1: an idle bus keeps every strobe inactive
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !mem_cre_o));

    // R3: the address may not move while CRE stays high
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_cre_o && $past(mem_cre_o)) |-> $stable(mem_addr_o));

    // R4: WE# never rises without ADV# and CE# rising with it
    p_rise_together_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n_o) |-> (mem_adv_n_o && mem_ce_n_o));

    // R6: no output enable during register access
    p_oe_off_in_cfg_r6: assert property (@(posedge clk) disable iff (rst)
        mem_cre_o |-> (mem_oe_n_o && mem_lb_n_o && mem_ub_n_o));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: a refused read touches nothing on the bus
    p_err_no_bus_r10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (mem_ce_n_o && !mem_cre_o && !done_o));

endmodule

// File: tb/psram_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module psram_cfg_seq_tb_top;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int CW = 8;

    typedef struct {
        logic [AW-1:0] addr;
        logic [AW-1:0] raddr;
        int            setup, adv, we, hold, acc;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0, rd_req_i = 1'b0, reg_sel_i = 1'b0;
    logic [AW-1:0] cfg_val_i = '0, arr_addr_i = '0;
    logic [CW-1:0] t_setup_i = '0, t_adv_i = '0, t_we_i = '0, t_hold_i = '0, t_acc_i = '0;
    logic          busy_o, done_o, err_o;
    logic [DW-1:0] rd_data_o, mem_dq_i;
    logic [AW-1:0] mem_addr_o;
    logic          mem_cre_o, mem_ce_n_o, mem_adv_n_o, mem_we_n_o, mem_oe_n_o;
    logic          mem_lb_n_o, mem_ub_n_o;

    int n_chk = 0, n_fail = 0, n_push = 0, n_done = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    // Memory model: read data is a fixed scramble of the address.
    assign mem_dq_i = (!mem_oe_n_o && !mem_ce_n_o && !mem_cre_o)
                      ? (mem_addr_o[DW-1:0] ^ 16'h5A3C) : '0;

    psram_cfg_seq dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .rd_req_i(rd_req_i),
        .reg_sel_i(reg_sel_i), .cfg_val_i(cfg_val_i), .arr_addr_i(arr_addr_i),
        .t_setup_i(t_setup_i), .t_adv_i(t_adv_i), .t_we_i(t_we_i),
        .t_hold_i(t_hold_i), .t_acc_i(t_acc_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rd_data_o(rd_data_o),
        .mem_addr_o(mem_addr_o), .mem_cre_o(mem_cre_o), .mem_ce_n_o(mem_ce_n_o),
        .mem_adv_n_o(mem_adv_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_lb_n_o(mem_lb_n_o), .mem_ub_n_o(mem_ub_n_o), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int clamp1(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    // Driver: waits for idle, pushes the expected item, pulses the request.
    task automatic do_write(input bit sel, input logic [AW-1:0] val, input logic [AW-1:0] ra,
                            input int ts, input int tadv, input int twe, input int th,
                            input int tacc, input bit poke);
        exp_t e;
        while (busy_o) @(negedge clk);
        e.addr  = {val[20], sel, val[18:0]};
        e.raddr = ra;
        e.setup = clamp1(ts);  e.adv = clamp1(tadv); e.we = clamp1(twe);
        e.hold  = clamp1(th);  e.acc = clamp1(tacc);
        e.data  = ra[DW-1:0] ^ 16'h5A3C;
        q.push_back(e);
        n_push++;
        reg_sel_i = sel; cfg_val_i = val; arr_addr_i = ra;
        t_setup_i = CW'(ts); t_adv_i = CW'(tadv); t_we_i = CW'(twe);
        t_hold_i = CW'(th); t_acc_i = CW'(tacc);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            reg_sel_i = ~sel; cfg_val_i = ~val; arr_addr_i = ~ra;
            t_setup_i = 8'd2; req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: measures each phase at the pins and compares on done.
    int c_setup, c_adv, c_we, c_hold, c_acc;
    logic [AW-1:0] w_addr, r_addr;
    bit oe_bad, hold_bad, rise_bad, prev_we_low, busy_bad;

    always @(negedge clk) begin
        if (rst) begin
            c_setup = 0; c_adv = 0; c_we = 0; c_hold = 0; c_acc = 0;
            oe_bad = 0; hold_bad = 0; rise_bad = 0; prev_we_low = 0; busy_bad = 0;
            w_addr = '0; r_addr = '0;
        end else begin
            if (mem_cre_o && (!mem_oe_n_o || !mem_lb_n_o || !mem_ub_n_o)) oe_bad = 1;
            if (mem_cre_o && !mem_ce_n_o && mem_adv_n_o && mem_we_n_o) c_setup++;
            else if (mem_cre_o && !mem_ce_n_o && !mem_adv_n_o && mem_we_n_o) c_adv++;
            else if (mem_cre_o && !mem_ce_n_o && !mem_adv_n_o && !mem_we_n_o) begin
                c_we++; w_addr = mem_addr_o;
            end else if (mem_cre_o && mem_ce_n_o && mem_adv_n_o && mem_we_n_o) begin
                c_hold++; if (mem_addr_o != w_addr) hold_bad = 1;
            end else if (!mem_cre_o && !mem_oe_n_o && !mem_ce_n_o && !mem_adv_n_o
                         && !mem_lb_n_o && !mem_ub_n_o) begin
                c_acc++; r_addr = mem_addr_o;
            end
            if (prev_we_low && mem_we_n_o && !(mem_ce_n_o && mem_adv_n_o)) rise_bad = 1;
            prev_we_low = !mem_we_n_o;
            if (done_o) begin
                exp_t e;
                n_done++;
                if (busy_o) busy_bad = 1;
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected done", n_done, n_push);
                end else begin
                    e = q.pop_front();
                    chk(w_addr == e.addr, "R3 register word on address bus", w_addr, e.addr);
                    chk(c_setup == e.setup, "R4 setup cycles", c_setup, e.setup);
                    chk(c_adv == e.adv, "R4 ADV-only cycles", c_adv, e.adv);
                    chk(c_we == e.we, "R4 WE pulse cycles", c_we, e.we);
                    chk(!rise_bad, "R4 strobes rise together", rise_bad, 0);
                    chk(c_hold == e.hold && !hold_bad, "R5 hold cycles", c_hold, e.hold);
                    chk(!oe_bad, "R6 OE/LB/UB high with CRE", oe_bad, 0);
                    chk(c_acc == e.acc && r_addr == e.raddr, "R8 read access", c_acc, e.acc);
                    chk(rd_data_o == e.data, "R9 read data", rd_data_o, e.data);
                    chk(!busy_bad, "R2 busy low with done", busy_bad, 0);
                end
                c_setup = 0; c_adv = 0; c_we = 0; c_hold = 0; c_acc = 0;
                oe_bad = 0; hold_bad = 0; rise_bad = 0; busy_bad = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset / idle state
        chk({mem_ce_n_o, mem_adv_n_o, mem_we_n_o, mem_oe_n_o, mem_lb_n_o, mem_ub_n_o} == 6'h3F
            && !mem_cre_o, "R1 idle strobes",
            {mem_cre_o, mem_ce_n_o, mem_adv_n_o, mem_we_n_o, mem_oe_n_o}, 5'h0F);
        chk(!busy_o && !done_o && !err_o, "R1 idle status", {busy_o, done_o, err_o}, 0);

        // R10: read request refused
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        chk(err_o && mem_ce_n_o && !mem_cre_o && !busy_o, "R10 error pulse, bus quiet",
            {err_o, mem_ce_n_o, mem_cre_o, busy_o}, 4'b1100);
        @(negedge clk);
        chk(!err_o && !done_o && !busy_o, "R10 error one cycle", {err_o, done_o, busy_o}, 0);

        // R3/R4: all-ones lengths, bus register selected
        do_write(1'b1, 21'h1ABCDE, 21'h00123, 1, 1, 1, 1, 1, 1'b0);
        // R3: bit 19 set in value but refresh register selected
        do_write(1'b0, 21'h0F0F0F, 21'h04567, 3, 2, 4, 2, 5, 1'b0);
        // R7: zero lengths become one cycle
        do_write(1'b1, 21'h000000, 21'h1FFFF, 0, 0, 0, 0, 0, 1'b0);
        // R2: request pulsed mid-sequence is ignored
        do_write(1'b0, 21'h1FFFFF, 21'h0BEEF, 7, 1, 2, 6, 3, 1'b1);
        do_write(1'b1, 21'h080000, 21'h0A5A5, 2, 5, 1, 1, 8, 1'b0);

        repeat (5) @(negedge clk);
        chk(n_done == n_push && q.size() == 0, "R2 one write per accepted request",
            n_done, n_push);
        chk(!busy_o && mem_ce_n_o && !mem_cre_o, "R1 idle after sequences",
            {busy_o, mem_ce_n_o, mem_cre_o}, 3'b010);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule